// File: doc/BRIEF.md
# Lithium Cell Pulse Charge Controller

This block gates an external current-limited charger into a single lithium cell. It works from digital samples that arrive ready-made: cell voltage, cell temperature, a flag that shows a charger is present, and a flag that shows the samples are valid. It drives two active-low gates. The recovery gate lets a small trickle current into a deeply discharged cell. The fast gate switches in the full charger current.

A host starts a fast charge with a start strobe. When the auto-start configuration bit is set, plugging in the charger also starts a charge. Fast charge first runs a bulk phase. Once the cell reaches the constant-voltage threshold it moves to a pulse phase: the gate is held on for a fixed window, then released until the voltage sags again. When the off-time of one pulse grows to fifteen windows, the charge is complete. Several safety paths also end the charge: over-temperature, an 8-bit charge-time countdown, charger removal, a stop strobe, and the host line held low.

All timing counts a single prescaled tick input, so the tick rate sets the real-time scale. One exception is the length of the short removal-test gap, which counts clock cycles.

Top module: `pchg_ctrl`

## Requirements
- R1: `trickle_n_o` is low exactly when `src_i` is 1 and `vbat_i` < `V_LB`, independent of temperature, auto-start bit and charge state.
- R2: A `start_i` strobe always initiates a charge. A 0→1 change of `src_i` initiates a charge only while `auto_src_i` is 1; with `auto_src_i` 0 it has no effect.
- R3: After initiation, fast charge waits while any of these holds: temperature outside `T_LO`..`T_HI` (inclusive), `src_i` 0, `valid_i` 0, or `vbat_i` < `V_LB`. It begins as soon as none holds, without a new strobe.
- R4: While the fast gate is in an on phase, it goes high for exactly `GAP_CYC` clock cycles once every `GAP_TICKS` ticks.
- R5: The bulk phase keeps `fast_n_o` low until `vbat_i` ≥ `V_CV`. Each such crossing keeps it low for `HOLD_TICKS` ticks and then high. When `vbat_i` falls below `V_CV`, it goes low again.
- R6: If `fast_n_o` stays high in the pulse phase for `DECAY_PERIODS`×`HOLD_TICKS` ticks, the charge ends with the complete code.
- R7: `status_o` encodes 2'b00 no charger, 2'b01 charging (fast charge or trickle recovery), 2'b10 charger present and idle, 2'b11 complete. The complete code holds until a `stat_wr_i` strobe.
- R8: A temperature above `T_MAX` during fast charge ends it with the complete code and both gates high.
- R9: Removal of `src_i`, a `stop_i` strobe, or `host_line_i` low for `LOW_TICKS` ticks while `auto_src_i` is 0 aborts the charge without the complete code. With `auto_src_i` 1, a low host line has no effect.
- R10: `ctime_o` loads from `ctime_cfg_i` at fast-charge start and falls by one every `TIMER_TICKS` ticks. At zero the charge ends with the complete code. `ctime_wr_i` overwrites it at any time.
- R11: After reset both gates are high and `status_o` is 2'b00. After any end of charge, a charger that stays connected does not restart charging; a fresh initiation is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled timebase strobe |
| vbat_i | input | VW | Cell voltage sample, unsigned |
| temp_i | input | TW | Temperature sample, signed, 0.125 °C units |
| src_i | input | 1 | Charger present |
| valid_i | input | 1 | Samples valid |
| start_i | input | 1 | Start charge strobe |
| stop_i | input | 1 | Stop charge strobe |
| stat_wr_i | input | 1 | Status write strobe, clears complete code |
| auto_src_i | input | 1 | Auto-start on charger connect enable |
| host_line_i | input | 1 | Host data line level |
| ctime_cfg_i | input | 8 | Stored charge-time reload value |
| ctime_wr_i | input | 1 | Charge-time overwrite strobe |
| ctime_wdata_i | input | 8 | Charge-time overwrite value |
| trickle_n_o | output | 1 | Recovery gate, active low |
| fast_n_o | output | 1 | Fast-charge gate, active low |
| status_o | output | 2 | Charge status code |
| ctime_o | output | 8 | Charge-time counter value |

## Verification
The bench targets the pulse timing edges. It checks that the gate stays low through the whole hold window after a crossing, and that a voltage sag re-arms the gate. A design that counted off-time from the wrong point, or failed to re-arm, would end early or never end. It counts the exact number of high cycles in one and two gap periods, which catches an off-by-one gap length. It also separates aborts from completions: a design that latched the complete code on a stop or on charger removal, or that restarted on a charger left connected, shows the wrong status code. Deferral is checked for each blocking condition, with the charge required to resume without a second strobe. The countdown is checked for its reload value, its rate, its terminal count, and a host overwrite that extends the charge.

// File: rtl/pchg_pkg.sv
package pchg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BULK,
    ST_PON,
    ST_POFF
  } chg_state_e;

  typedef enum logic [1:0] {
    CS_NOSRC    = 2'b00,
    CS_CHARGING = 2'b01,
    CS_SRCPRES  = 2'b10,
    CS_COMPLETE = 2'b11
  } chg_stat_e;
endpackage

// File: rtl/pchg_hostlow.sv
module pchg_hostlow #(
  parameter int LOW_TICKS = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic line_i,
  output logic held_o
);
  localparam int CW = $clog2(LOW_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(LOW_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (line_i)            cnt <= '0;
    else if (tick_i && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign held_o = (cnt == LIM);

  // R9: a released line always clears the held-low indication
  p_release_clears_r9: assert property (@(posedge clk) disable iff (rst)
    line_i |=> !held_o);
endmodule

// File: rtl/pchg_gap.sv
module pchg_gap #(
  parameter int GAP_TICKS = 55,
  parameter int GAP_CYC   = 1350
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  output logic gap_o
);
  localparam int PW  = $clog2(GAP_TICKS);
  localparam int GCW = $clog2(GAP_CYC + 1);
  localparam logic [PW-1:0]  P_LAST = PW'(GAP_TICKS - 1);
  localparam logic [GCW-1:0] G_LEN  = GCW'(GAP_CYC);

  logic [PW-1:0]  pcnt;
  logic [GCW-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      pcnt <= '0;
      gcnt <= '0;
    end else begin
      if (tick_i) pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
      if (tick_i && pcnt == P_LAST) gcnt <= G_LEN;
      else if (gcnt != '0)          gcnt <= gcnt - 1'b1;
    end
  end

  assign gap_o = (gcnt != '0);

  // R4: no gap outside fast charge
  p_gap_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !gap_o);
endmodule

// File: rtl/pchg_ctimer.sv
module pchg_ctimer #(
  parameter int TIMER_TICKS = 56000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       wr_i,
  input  logic [7:0] wr_val_i,
  output logic [7:0] cnt_o,
  output logic       zero_o
);
  localparam int PW = $clog2(TIMER_TICKS);
  localparam logic [PW-1:0] P_LAST = PW'(TIMER_TICKS - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || load_i || !run_i) pcnt <= '0;
    else if (tick_i)             pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (wr_i)   cnt_o <= wr_val_i;
    else if (load_i) cnt_o <= load_val_i;
    else if (run_i && tick_i && pcnt == P_LAST && cnt_o != 8'd0)
      cnt_o <= cnt_o - 8'd1;
  end

  assign zero_o = (cnt_o == 8'd0);

  // R10: without a load or write the counter never rises
  p_no_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_i && !load_i) |=> (cnt_o <= $past(cnt_o)));
endmodule

// File: rtl/pchg_ctrl.sv
module pchg_ctrl
  import pchg_pkg::*;
#(
  parameter int VW            = 10,
  parameter int TW            = 11,
  parameter int V_LB          = 615,
  parameter int V_CV          = 861,
  parameter int T_LO          = 0,
  parameter int T_HI          = 320,
  parameter int T_MAX         = 400,
  parameter int HOLD_TICKS    = 875,
  parameter int DECAY_PERIODS = 15,
  parameter int GAP_TICKS     = 55,
  parameter int GAP_CYC       = 1350,
  parameter int TIMER_TICKS   = 56000,
  parameter int LOW_TICKS     = 2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [VW-1:0]        vbat_i,
  input  logic signed [TW-1:0] temp_i,
  input  logic                 src_i,
  input  logic                 valid_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 stat_wr_i,
  input  logic                 auto_src_i,
  input  logic                 host_line_i,
  input  logic [7:0]           ctime_cfg_i,
  input  logic                 ctime_wr_i,
  input  logic [7:0]           ctime_wdata_i,
  output logic                 trickle_n_o,
  output logic                 fast_n_o,
  output logic [1:0]           status_o,
  output logic [7:0]           ctime_o
);
  localparam int OFF_LIMIT = DECAY_PERIODS * HOLD_TICKS;
  localparam int HW = $clog2(HOLD_TICKS);
  localparam int OW = $clog2(OFF_LIMIT);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [OW-1:0] OFF_LAST  = OW'(OFF_LIMIT - 1);
  localparam logic [VW-1:0] VLB = VW'(V_LB);
  localparam logic [VW-1:0] VCV = VW'(V_CV);
  localparam logic signed [TW-1:0] TLO  = TW'(T_LO);
  localparam logic signed [TW-1:0] THI  = TW'(T_HI);
  localparam logic signed [TW-1:0] TMAX = TW'(T_MAX);

  chg_state_e st, st_d;
  logic          src_q, done_q;
  logic [HW-1:0] hold_cnt;
  logic [OW-1:0] off_cnt;
  logic          host_held, gap, ct_zero, load_ct, term_done;
  logic          fast, init_ev, go_ok, abort, over, decay_hit, low_v, at_cv;

  pchg_hostlow #(.LOW_TICKS(LOW_TICKS)) u_hostlow (
    .clk(clk), .rst(rst), .tick_i(tick_i), .line_i(host_line_i), .held_o(host_held));

  pchg_gap #(.GAP_TICKS(GAP_TICKS), .GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(fast), .gap_o(gap));

  pchg_ctimer #(.TIMER_TICKS(TIMER_TICKS)) u_ctimer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(fast), .load_i(load_ct),
    .load_val_i(ctime_cfg_i), .wr_i(ctime_wr_i), .wr_val_i(ctime_wdata_i),
    .cnt_o(ctime_o), .zero_o(ct_zero));

  assign fast    = (st == ST_BULK) || (st == ST_PON) || (st == ST_POFF);
  assign low_v   = (vbat_i < VLB);
  assign at_cv   = (vbat_i >= VCV);
  assign init_ev = start_i || (auto_src_i && src_i && !src_q);
  assign go_ok   = (temp_i >= TLO) && (temp_i <= THI) && src_i && valid_i && !low_v;
  assign abort   = !src_i || stop_i || (host_held && !auto_src_i);
  assign over    = (temp_i > TMAX);
  assign decay_hit = (st == ST_POFF) && tick_i && at_cv && (off_cnt == OFF_LAST);

  always_comb begin
    st_d      = st;
    load_ct   = 1'b0;
    term_done = 1'b0;
    unique case (st)
      ST_IDLE:  if (init_ev) st_d = ST_ARMED;
      ST_ARMED: begin
        if (stop_i || (host_held && !auto_src_i)) st_d = ST_IDLE;
        else if (go_ok) begin
          st_d    = ST_BULK;
          load_ct = 1'b1;
        end
      end
      default: begin
        if (abort) st_d = ST_IDLE;
        else if (over || ct_zero || decay_hit) begin
          st_d      = ST_IDLE;
          term_done = 1'b1;
        end else begin
          case (st)
            ST_BULK: if (at_cv) st_d = ST_PON;
            ST_PON:  if (tick_i && hold_cnt == HOLD_LAST) st_d = at_cv ? ST_POFF : ST_BULK;
            ST_POFF: if (!at_cv) st_d = ST_PON;
            default: st_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      src_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_d;
      src_q  <= src_i;
      done_q <= term_done || (done_q && !stat_wr_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st != ST_PON) hold_cnt <= '0;
    else if (tick_i)         hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || st != ST_POFF) off_cnt <= '0;
    else if (tick_i)          off_cnt <= off_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trickle_n_o <= 1'b1;
      fast_n_o    <= 1'b1;
      status_o    <= CS_NOSRC;
    end else begin
      trickle_n_o <= !(src_i && low_v);
      fast_n_o    <= !(((st == ST_BULK) || (st == ST_PON)) && !gap);
      if (done_q)                       status_o <= CS_COMPLETE;
      else if (fast || (src_i && low_v)) status_o <= CS_CHARGING;
      else if (src_i)                   status_o <= CS_SRCPRES;
      else                              status_o <= CS_NOSRC;
    end
  end

  // R1: a present charger and a low cell always open the recovery gate
  p_trickle_on_r1: assert property (@(posedge clk) disable iff (rst)
    (src_i && low_v) |=> !trickle_n_o);

  // R7: complete code persists while no status write arrives
  p_complete_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (status_o == CS_COMPLETE && !stat_wr_i && !$past(stat_wr_i)) |=> (status_o == CS_COMPLETE));

  // R9: a stop strobe during fast charge releases the gate
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    (fast && stop_i) |=> ##1 fast_n_o);

  // R6: the decay counter never passes its limit
  p_decay_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POFF) |-> (off_cnt <= OFF_LAST));

  // R11: idle means both gates high one cycle later
  p_idle_gates_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(src_i && low_v)) |=> (fast_n_o && trickle_n_o));
endmodule

// File: tb/test_pchg_ctrl.sv
module test_pchg_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [9:0] vbat = 10'd700;
  logic signed [10:0] temp = 11'sd200;
  logic src = 1'b0, valid = 1'b1, start = 1'b0, stop = 1'b0, statwr = 1'b0;
  logic auto_src = 1'b0, host = 1'b1, ctwr = 1'b0;
  logic [7:0] ctcfg = 8'd255, ctwdata = 8'd0;
  logic trickle_n, fast_n;
  logic [1:0] status;
  logic [7:0] ctime;
  int checks = 0, errors = 0;
  logic finished = 1'b0;
  int tdiv = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  pchg_ctrl #(.HOLD_TICKS(8), .GAP_TICKS(16), .GAP_CYC(2), .TIMER_TICKS(8), .LOW_TICKS(8)) i_pchg_ctrl (
    .clk(clk), .rst(rst), .tick_i(tick), .vbat_i(vbat), .temp_i(temp), .src_i(src),
    .valid_i(valid), .start_i(start), .stop_i(stop), .stat_wr_i(statwr),
    .auto_src_i(auto_src), .host_line_i(host), .ctime_cfg_i(ctcfg),
    .ctime_wr_i(ctwr), .ctime_wdata_i(ctwdata), .trickle_n_o(trickle_n),
    .fast_n_o(fast_n), .status_o(status), .ctime_o(ctime));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lo);
    checks++;
    if (act < lo) begin
      errors++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lows(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (!fast_n) c++;
    end
  endtask

  task automatic p_start();  start = 1'b1;  w(1); start = 1'b0;  endtask
  task automatic p_stop();   stop = 1'b1;   w(1); stop = 1'b0;   endtask
  task automatic p_statwr(); statwr = 1'b1; w(1); statwr = 1'b0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    w(5);
    rst = 1'b0;
    w(2);
    chk("R11 reset trickle", trickle_n, 1);
    chk("R11 reset fast", fast_n, 1);
    chk("R11 reset status", status, 0);

    // R1 trickle recovery
    src = 1'b1; vbat = 10'd500; w(4);
    chk("R1 trickle low", trickle_n, 0);
    chk("R7 trickle status", status, 1);
    temp = 11'sd500; w(4);
    chk("R1 trickle ignores temp", trickle_n, 0);
    temp = 11'sd200; vbat = 10'd615; w(4);
    chk("R1 trickle off at threshold", trickle_n, 1);
    chk("R7 source present", status, 2);
    src = 1'b0; w(4);
    chk("R7 no source", status, 0);

    // R2 initiation, R4 gaps, R9 stop, R11 no restart
    src = 1'b1; w(40);
    chk("R2 connect without auto", status, 2);
    chk("R2 connect without auto gate", fast_n, 1);
    p_start(); w(8);
    chk("R2 start cmd status", status, 1);
    lows(64, c);  chk("R4 one gap period", c, 62);
    lows(128, c); chk("R4 two gap periods", c, 124);
    p_stop(); w(4);
    chk("R9 stop status", status, 2);
    chk("R9 stop gate", fast_n, 1);
    w(100);
    chk("R11 no restart status", status, 2);
    chk("R11 no restart gate", fast_n, 1);

    auto_src = 1'b1; src = 1'b0; w(8); src = 1'b1; w(8);
    chk("R2 auto connect", status, 1);
    host = 1'b0; w(60);
    chk("R9 host low ignored with auto", status, 1);
    host = 1'b1; w(4); auto_src = 1'b0;
    host = 1'b0; w(60);
    chk("R9 host low abort", status, 2);
    chk("R9 host low gate", fast_n, 1);
    host = 1'b1; w(4);

    // R3 deferral
    temp = -11'sd8; p_start(); w(40);
    chk("R3 cold defer", status, 2);
    chk("R3 cold gate", fast_n, 1);
    temp = 11'sd200; w(8);
    chk("R3 cold resume", status, 1);
    lows(8, c); chk_ge("R3 cold resume gate", c, 6);
    p_stop(); w(4);
    valid = 1'b0; p_start(); w(40);
    chk("R3 invalid defer", status, 2);
    valid = 1'b1; w(8);
    chk("R3 valid resume", status, 1);
    p_stop(); w(4);
    vbat = 10'd600; p_start(); w(40);
    chk("R3 low cell gate", fast_n, 1);
    chk("R3 low cell trickle", trickle_n, 0);
    vbat = 10'd700; w(8);
    chk("R3 low cell trickle off", trickle_n, 1);
    lows(8, c); chk_ge("R3 low cell resume", c, 6);
    p_stop(); w(4);
    src = 1'b0; w(4); p_start(); w(40);
    chk("R3 no source defer", status, 0);
    src = 1'b1; w(8);
    chk("R3 source resume", status, 1);
    p_stop(); w(4);

    // R8 over temperature
    p_start(); w(8); temp = 11'sd401; w(4);
    chk("R8 hot complete", status, 3);
    chk("R8 hot fast gate", fast_n, 1);
    chk("R8 hot trickle gate", trickle_n, 1);
    w(20);
    chk("R7 complete latched", status, 3);
    temp = 11'sd200; p_statwr(); w(4);
    chk("R7 cleared by write", status, 2);

    // R9 removal
    p_start(); w(8); src = 1'b0; w(4);
    chk("R9 removal status", status, 0);
    src = 1'b1; w(44);
    chk("R11 reconnect no restart", fast_n, 1);

    // R5, R6 pulse phase
    p_start(); w(20); vbat = 10'd900;
    w(4); lows(16, c); chk_ge("R5 hold low", c, 14);
    w(24); lows(16, c); chk("R5 released after hold", c, 0);
    chk("R6 still charging", status, 1);
    w(40); vbat = 10'd700; w(4);
    lows(8, c); chk_ge("R5 re-arm on sag", c, 6);
    vbat = 10'd900; w(440);
    chk("R6 before decay limit", status, 1);
    w(120);
    chk("R6 decay complete", status, 3);
    chk("R6 decay gate", fast_n, 1);
    p_statwr(); vbat = 10'd700; w(4);

    // R10 charge timer
    ctcfg = 8'd5; p_start(); w(8);
    chk("R10 reload", ctime, 5);
    w(42);
    chk("R10 decrement", ctime, 4);
    w(90);
    chk("R10 still running", status, 1);
    w(60);
    chk("R10 expired", status, 3);
    p_statwr(); w(4);
    p_start(); w(20);
    ctwdata = 8'd100; ctwr = 1'b1; w(1); ctwr = 1'b0;
    chk("R10 overwrite", ctime, 100);
    w(200);
    chk("R10 overwrite extends", status, 1);
    p_stop(); w(4);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule